// File: doc/BRIEF.md
# Deferred Error Status Register Redirector

This block owns the storage behind one deferred-error status alias. Three 64-bit copies sit behind it: a physical register, a virtual copy owned by privilege level 2, and a virtual copy owned by privilege level 3. Each request carries a valid strobe, a read/write flag, a 16-bit system-register encoding, write data and the current privilege level (0 to 3). The block resolves each request in the same cycle to one of five outcomes: one of the three copies, a read-as-zero/write-ignored response, or an undefined-instruction trap. The outcome depends on a set of static control inputs.

A hardware deferral event, raised when an error barrier defers a delegated error, captures a syndrome into the level-3 virtual copy. The captured value can be read through the physical alias in the very next cycle. No state machine is needed. Routing is a purely combinational priority decode, and the only sequential element is the bank of three copies.

Top module: `dsr_redirect`

## Requirements
- R1: Every copy keeps only bit 31 (deferred flag), bit 24 (syndrome type) and bits 23:0 (syndrome). Bits 63:32 and 30:25 always read as zero and ignore written ones.
- R2: A deferral event captures only when the delegation enable is 1 and the current level is 0, 1 or 2. A capture sets bit 31 and loads bit 24 and bits 23:0 from the syndrome inputs into the level-3 virtual copy. In all other cases the event changes nothing.
- R3: The encoding is packed as op0[15:14], op1[13:11], CRn[10:7], CRm[6:3], op2[2:0]. The physical alias is 16'hC609 and the level-3 virtual copy is 16'hF609. Any other encoding selects nothing, returns zero data, raises no trap and changes no copy.
- R4: A direct access to the level-3 virtual copy reaches it only at level 3 with the delegation feature present. Otherwise the access traps.
- R5: A physical-alias access traps at level 0, and at any level when the error-extension feature is absent.
- R6: At level 1, a physical-alias access resolves in this priority order:
  - to the level-2 virtual copy when level 2 is enabled and either the AMO control is 1, or the double-fault feature is present with its extension enabled and TMEA is 1;
  - otherwise to the level-3 virtual copy when the delegation enable is 1;
  - otherwise to read-as-zero/write-ignored when level 3 exists, the core is not halted and EA is 1;
  - otherwise to the physical register.
- R7: At level 2, a physical-alias access follows the same order without the level-2 virtual step. The AMO and TMEA controls have no effect there.
- R8: At level 3 (with the error extension present), a physical-alias access always reaches the physical register.
- R9: A value captured by a deferral event is returned by a physical-alias read in the next cycle.
- R10: When a capture and a software write hit the level-3 virtual copy in the same cycle, the capture wins.
- R11: `rsp_target` is one-hot: bit0 physical, bit1 level-2 virtual, bit2 level-3 virtual, bit3 read-as-zero, bit4 trap. `rsp_trap` equals bit4, and read data is zero for read-as-zero and trap outcomes.
- R12: After reset, with no valid request, every output is zero. Writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_enc | input | 16 | System-register encoding |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Current privilege level |
| cfg_err_ext | input | 1 | Error-extension feature present |
| cfg_dlg_present | input | 1 | Delegation feature present |
| cfg_dlg_en | input | 1 | Effective delegation enable |
| cfg_lvl2_en | input | 1 | Level 2 enabled |
| cfg_amo | input | 1 | Hypervisor AMO routing control |
| cfg_dfault | input | 1 | Double-fault feature present |
| cfg_hext_en | input | 1 | Hypervisor extension register enabled |
| cfg_tmea | input | 1 | TMEA routing control |
| cfg_lvl3_ex | input | 1 | Level 3 exists |
| cfg_halted | input | 1 | Core halted for debug |
| cfg_ea | input | 1 | External-abort routing control |
| evt_defer | input | 1 | Deferral event from the error barrier |
| evt_ids | input | 1 | Syndrome type to capture |
| evt_iss | input | 24 | Syndrome to capture |
| rsp_rdata | output | 64 | Read data |
| rsp_trap | output | 1 | Undefined-instruction trap |
| rsp_target | output | 5 | One-hot outcome code |

## Verification
The assertions check four things on every cycle:
- the outcome code stays one-hot;
- reserved bits stay clear in all three copies;
- level-3 and level-0 accesses are routed as required;
- a capture always leaves the deferred flag set and overrides a concurrent write, and a read-as-zero write leaves all copies untouched.

Only the bench scenarios can show the remaining behaviour: the full level-1 and level-2 priority chains under each control combination, next-cycle visibility of a captured syndrome through the physical alias, and ignored deferral events seen through a later read.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int XLEN     = 64;
    localparam int ISS_W    = 24;
    localparam int IDS_BIT  = 24;
    localparam int FLAG_BIT = 31;
    localparam int ENC_W    = 16;
    localparam int LVL_W    = 2;
    localparam int N_COPY   = 3;
    localparam int TGT_W    = 5;

    // one-hot outcome positions
    localparam int T_PHYS = 0;
    localparam int T_V2   = 1;
    localparam int T_V3   = 2;
    localparam int T_RAZ  = 3;
    localparam int T_UND  = 4;

    localparam logic [XLEN-1:0] KEEP_MASK =
        (XLEN'(1) << FLAG_BIT) | (XLEN'(1) << IDS_BIT) | ((XLEN'(1) << ISS_W) - XLEN'(1));

    // op0, op1, CRn, CRm, op2
    localparam logic [ENC_W-1:0] ENC_PHYS = {2'd3, 3'd0, 4'd12, 4'd1, 3'd1};
    localparam logic [ENC_W-1:0] ENC_V3   = {2'd3, 3'd6, 4'd12, 4'd1, 3'd1};

    typedef logic [TGT_W-1:0] tgt_t;
endpackage

// File: rtl/dsr_route.sv
module dsr_route
    import dsr_pkg::*;
(
    input  logic             req_valid,
    input  logic [ENC_W-1:0] req_enc,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             cfg_err_ext,
    input  logic             cfg_dlg_present,
    input  logic             cfg_dlg_en,
    input  logic             cfg_lvl2_en,
    input  logic             cfg_amo,
    input  logic             cfg_dfault,
    input  logic             cfg_hext_en,
    input  logic             cfg_tmea,
    input  logic             cfg_lvl3_ex,
    input  logic             cfg_halted,
    input  logic             cfg_ea,
    output tgt_t             tgt
);
    logic to_lvl2;
    logic zero_route;

    always_comb begin
        to_lvl2    = cfg_lvl2_en && (cfg_amo || (cfg_dfault && cfg_hext_en && cfg_tmea));
        zero_route = cfg_lvl3_ex && !cfg_halted && cfg_ea;
    end

    always_comb begin
        tgt = '0;
        if (req_valid) begin
            if (req_enc == ENC_V3) begin
                if (cfg_dlg_present && cur_level == 2'd3) tgt[T_V3]  = 1'b1;
                else                                      tgt[T_UND] = 1'b1;
            end else if (req_enc == ENC_PHYS) begin
                if (!cfg_err_ext || cur_level == 2'd0)    tgt[T_UND]  = 1'b1;
                else if (cur_level == 2'd3)               tgt[T_PHYS] = 1'b1;
                else if (cur_level == 2'd1 && to_lvl2)    tgt[T_V2]   = 1'b1;
                else if (cfg_dlg_en)                      tgt[T_V3]   = 1'b1;
                else if (zero_route)                      tgt[T_RAZ]  = 1'b1;
                else                                      tgt[T_PHYS] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsr_bank.sv
module dsr_bank
    import dsr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_COPY-1:0]           wr_en,
    input  logic [XLEN-1:0]             wdata,
    input  logic                        cap_en,
    input  logic                        cap_ids,
    input  logic [ISS_W-1:0]            cap_iss,
    output logic [N_COPY-1:0][XLEN-1:0] copy_q
);
    logic [XLEN-1:0] cap_word;

    always_comb begin
        cap_word                = '0;
        cap_word[FLAG_BIT]      = 1'b1;
        cap_word[IDS_BIT]       = cap_ids;
        cap_word[ISS_W-1:0]     = cap_iss;
    end

    for (genvar i = 0; i < N_COPY; i++) begin : g_copy
        if (i == T_V3) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         copy_q[i] <= '0;
                else if (cap_en)    copy_q[i] <= cap_word;
                else if (wr_en[i])  copy_q[i] <= wdata & KEEP_MASK;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         copy_q[i] <= '0;
                else if (wr_en[i])  copy_q[i] <= wdata & KEEP_MASK;
            end
        end

        AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (copy_q[i] & ~KEEP_MASK) == '0);  // R1
    end

    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> copy_q[T_V3][FLAG_BIT]);  // R2
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && wr_en[T_V3]) |=> copy_q[T_V3][ISS_W-1:0] == $past(cap_iss));  // R10
endmodule

// File: rtl/dsr_redirect.sv
module dsr_redirect
    import dsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [15:0]      req_enc,
    input  logic [63:0]      req_wdata,
    input  logic [1:0]       cur_level,
    input  logic             cfg_err_ext,
    input  logic             cfg_dlg_present,
    input  logic             cfg_dlg_en,
    input  logic             cfg_lvl2_en,
    input  logic             cfg_amo,
    input  logic             cfg_dfault,
    input  logic             cfg_hext_en,
    input  logic             cfg_tmea,
    input  logic             cfg_lvl3_ex,
    input  logic             cfg_halted,
    input  logic             cfg_ea,
    input  logic             evt_defer,
    input  logic             evt_ids,
    input  logic [23:0]      evt_iss,
    output logic [63:0]      rsp_rdata,
    output logic             rsp_trap,
    output logic [4:0]       rsp_target
);
    tgt_t                        tgt;
    logic [N_COPY-1:0]           wr_en;
    logic                        cap_en;
    logic [N_COPY-1:0][XLEN-1:0] copy_q;

    dsr_route u_route (
        .req_valid      (req_valid),
        .req_enc        (req_enc),
        .cur_level      (cur_level),
        .cfg_err_ext    (cfg_err_ext),
        .cfg_dlg_present(cfg_dlg_present),
        .cfg_dlg_en     (cfg_dlg_en),
        .cfg_lvl2_en    (cfg_lvl2_en),
        .cfg_amo        (cfg_amo),
        .cfg_dfault     (cfg_dfault),
        .cfg_hext_en    (cfg_hext_en),
        .cfg_tmea       (cfg_tmea),
        .cfg_lvl3_ex    (cfg_lvl3_ex),
        .cfg_halted     (cfg_halted),
        .cfg_ea         (cfg_ea),
        .tgt            (tgt)
    );

    always_comb begin
        cap_en = evt_defer && cfg_dlg_en && (cur_level != 2'd3);
        for (int i = 0; i < N_COPY; i++) begin
            wr_en[i] = req_valid && req_write && tgt[i];
        end
    end

    dsr_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wdata  (req_wdata),
        .cap_en (cap_en),
        .cap_ids(evt_ids),
        .cap_iss(evt_iss),
        .copy_q (copy_q)
    );

    always_comb begin
        rsp_rdata = '0;
        for (int i = 0; i < N_COPY; i++) begin
            if (tgt[i]) rsp_rdata = copy_q[i];
        end
        rsp_trap   = tgt[T_UND];
        rsp_target = tgt;
    end

    AST_TARGET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_target));  // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rsp_target == '0 && rsp_rdata == '0));  // R12
    AST_OTHER_ENC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_enc != ENC_PHYS && req_enc != ENC_V3) |-> (rsp_target == '0 && !rsp_trap));  // R3
    AST_V3_LOWER_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == ENC_V3 && cur_level != 2'd3) |-> rsp_trap);  // R4
    AST_LEVEL0_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == ENC_PHYS && cur_level == 2'd0) |-> rsp_trap);  // R5
    AST_LEVEL3_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_enc == ENC_PHYS && cur_level == 2'd3 && cfg_err_ext)
            |-> rsp_target[T_PHYS]);  // R8
    AST_RAZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rsp_target[T_RAZ] && !cap_en) |=> copy_q == $past(copy_q));  // R6
endmodule

// File: tb/dsr_redirect_tb.sv
module dsr_redirect_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic        req_valid, req_write;
    logic [15:0] req_enc;
    logic [63:0] req_wdata;
    logic [1:0]  cur_level;
    logic        cfg_err_ext, cfg_dlg_present, cfg_dlg_en, cfg_lvl2_en, cfg_amo;
    logic        cfg_dfault, cfg_hext_en, cfg_tmea, cfg_lvl3_ex, cfg_halted, cfg_ea;
    logic        evt_defer, evt_ids;
    logic [23:0] evt_iss;
    logic [63:0] rsp_rdata;
    logic        rsp_trap;
    logic [4:0]  rsp_target;

    localparam logic [15:0] E_PHYS = 16'hC609;
    localparam logic [15:0] E_V3   = 16'hF609;

    dsr_redirect u_dut (.*);

    logic [63:0] m_copy [3];
    int n_vec = 0;
    int n_bad = 0;

    function automatic logic [4:0] ref_tgt();
        if (!req_valid) return 5'b00000;
        if (req_enc == E_V3)
            return (cur_level == 2'd3 && cfg_dlg_present) ? 5'b00100 : 5'b10000;
        if (req_enc != E_PHYS) return 5'b00000;
        case (cur_level)
            2'd0: return 5'b10000;
            2'd3: return cfg_err_ext ? 5'b00001 : 5'b10000;
            default: begin
                if (!cfg_err_ext) return 5'b10000;
                if (cur_level == 2'd1 && cfg_lvl2_en &&
                    (cfg_amo || (cfg_dfault && cfg_hext_en && cfg_tmea))) return 5'b00010;
                if (cfg_dlg_en) return 5'b00100;
                if (cfg_lvl3_ex && !cfg_halted && cfg_ea) return 5'b01000;
                return 5'b00001;
            end
        endcase
    endfunction

    task automatic go(string tag);
        logic [4:0]  et;
        logic [63:0] ed;
        bit          cap;
        #2;
        et = ref_tgt();
        ed = et[0] ? m_copy[0] : et[1] ? m_copy[1] : et[2] ? m_copy[2] : 64'h0;
        n_vec++;
        if (rsp_target !== et || rsp_rdata !== ed || rsp_trap !== et[4]) begin
            n_bad++;
            $display("FAIL %s: target=%b data=%h trap=%b, expected target=%b data=%h trap=%b",
                     tag, rsp_target, rsp_rdata, rsp_trap, et, ed, et[4]);
        end
        cap = evt_defer && cfg_dlg_en && cur_level != 2'd3;
        if (req_valid && req_write)
            for (int k = 0; k < 3; k++)
                if (et[k] && !(k == 2 && cap)) m_copy[k] = req_wdata & 64'h0000_0000_81FF_FFFF;
        if (cap) m_copy[2] = {32'h0, 1'b1, 6'h0, evt_ids, evt_iss};
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_clear();
        {cfg_dlg_en, cfg_lvl2_en, cfg_amo, cfg_dfault, cfg_hext_en, cfg_tmea} = '0;
        {cfg_halted, cfg_ea} = '0;
        cfg_err_ext = 1'b1; cfg_dlg_present = 1'b1; cfg_lvl3_ex = 1'b1;
    endtask

    task automatic acc(input bit wr, input logic [15:0] enc, input logic [1:0] lvl,
                       input logic [63:0] d, input string tag);
        req_valid = 1'b1; req_write = wr; req_enc = enc; cur_level = lvl; req_wdata = d;
        go(tag);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run still busy, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 0; req_write = 0; req_enc = 0; req_wdata = 0; cur_level = 0;
        evt_defer = 0; evt_ids = 0; evt_iss = 0;
        cfg_clear();
        for (int k = 0; k < 3; k++) m_copy[k] = 64'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        go("R12 idle after reset");

        // R1 / R8: level-3 physical write of all ones, masked readback
        acc(1, E_PHYS, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R8 write");
        acc(0, E_PHYS, 3, 0, "R1 masked readback");
        // R4: direct level-3 copy
        acc(1, E_V3, 3, 64'hDEAD_BEEF_FFFF_FFFF, "R4 write");
        acc(0, E_V3, 3, 0, "R4 read");
        acc(0, E_V3, 2, 0, "R4 trap at level 2");
        acc(1, E_V3, 1, 64'h1, "R4 trap write at level 1");
        cfg_dlg_present = 0;
        acc(0, E_V3, 3, 0, "R4 trap feature absent");
        cfg_dlg_present = 1;
        // R5
        acc(0, E_PHYS, 0, 0, "R5 level 0 trap");
        cfg_err_ext = 0;
        acc(0, E_PHYS, 1, 0, "R5 no error extension");
        acc(0, E_PHYS, 3, 0, "R5 no error extension level 3");
        cfg_err_ext = 1;
        // R3
        acc(1, 16'hC60A, 3, 64'hFFFF, "R3 other encoding");
        acc(0, E_PHYS, 3, 0, "R3 physical unchanged");
        // R6 priority chain
        cfg_lvl2_en = 1; cfg_amo = 1; cfg_dlg_en = 1; cfg_ea = 1;
        acc(1, E_PHYS, 1, 64'h0000_0000_8012_3456, "R6 amo to level-2 copy");
        acc(0, E_PHYS, 1, 0, "R6 level-2 copy read");
        cfg_amo = 0; cfg_dfault = 1; cfg_hext_en = 1; cfg_tmea = 1;
        acc(0, E_PHYS, 1, 0, "R6 tmea path");
        cfg_hext_en = 0;
        acc(0, E_PHYS, 1, 0, "R6 extension off falls to delegation");
        cfg_hext_en = 1; cfg_lvl2_en = 0;
        acc(0, E_PHYS, 1, 0, "R6 level 2 disabled");
        cfg_dlg_en = 0;
        acc(1, E_PHYS, 1, 64'hFFFF_FFFF, "R6 zero route write ignored");
        acc(0, E_PHYS, 3, 0, "R6 physical unchanged after ignored write");
        cfg_halted = 1;
        acc(0, E_PHYS, 1, 0, "R6 halted reaches physical");
        cfg_halted = 0; cfg_lvl3_ex = 0;
        acc(0, E_PHYS, 1, 0, "R6 no level 3 reaches physical");
        cfg_lvl3_ex = 1;
        // R7
        cfg_lvl2_en = 1; cfg_amo = 1; cfg_dlg_en = 1;
        acc(0, E_PHYS, 2, 0, "R7 amo ignored at level 2");
        cfg_dlg_en = 0;
        acc(0, E_PHYS, 2, 0, "R7 zero route at level 2");
        cfg_ea = 0;
        acc(1, E_PHYS, 2, 64'h0100_0000_0100_0042, "R7 physical at level 2");
        cfg_clear();
        // R2 / R9
        cfg_dlg_en = 1; cur_level = 1;
        evt_defer = 1; evt_ids = 1; evt_iss = 24'hA5_5A_3C;
        go("R2 capture at level 1");
        evt_defer = 0;
        acc(0, E_PHYS, 1, 0, "R9 next-cycle read");
        cur_level = 3; evt_defer = 1; evt_iss = 24'h11_1111; evt_ids = 0;
        go("R2 event at level 3");
        evt_defer = 0;
        acc(0, E_V3, 3, 0, "R2 level 3 event ignored");
        cfg_dlg_en = 0; cur_level = 2; evt_defer = 1;
        go("R2 event with delegation off");
        evt_defer = 0;
        acc(0, E_V3, 3, 0, "R2 disabled event ignored");
        // R10
        cfg_dlg_en = 1; evt_defer = 1; evt_ids = 0; evt_iss = 24'h00_BEEF;
        acc(1, E_PHYS, 2, 64'h0000_0000_01FF_FFFF, "R10 capture and write");
        evt_defer = 0;
        acc(0, E_PHYS, 2, 0, "R10 capture won");

        // R11: mixed stimulus
        for (int n = 0; n < 400; n++) begin
            logic [3:0] pick;
            pick = 4'($urandom_range(0, 9));
            {cfg_err_ext, cfg_dlg_present, cfg_dlg_en, cfg_lvl2_en, cfg_amo, cfg_dfault} = 6'($urandom);
            {cfg_hext_en, cfg_tmea, cfg_lvl3_ex, cfg_halted, cfg_ea} = 5'($urandom);
            req_valid = ($urandom_range(0, 7) != 0);
            req_write = 1'($urandom);
            req_enc   = (pick < 5) ? E_PHYS : (pick < 9) ? E_V3 : 16'($urandom);
            req_wdata = {$urandom, $urandom};
            cur_level = 2'($urandom);
            evt_defer = ($urandom_range(0, 3) == 0);
            evt_ids   = 1'($urandom);
            evt_iss   = 24'($urandom);
            go("R11 mixed");
        end
        req_valid = 0; evt_defer = 0;
        go("R12 idle at end");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule